// File: doc/BRIEF.md
# Power-Gating Sequence Controller

This synchronous controller manages one switchable logic domain. When the domain reports idle, the controller first stops the domain clock. Stopping the clock keeps all state, and the clock can restart on the next cycle. While the clock is stopped, an idle counter runs. The supply is cut only when the idle period lasts long enough for the saving to repay the cost of waking up again. That break-even length is set through a port.

A full power-down runs in a fixed order: clock stop, output clamping, a retention save strobe, then the supply switches open. On a wake request the order is reversed: the switches close, a programmable settling count runs while the domain's internal nodes recharge, a restore strobe fires, the clock restarts, the clamp lifts, and only then is the domain reported usable. A wake request that arrives while the power-down is still in progress is remembered. It is served as soon as the sleep state has been reached.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: `sw_off_n` is always the exact complement of `sw_off`. `sw_off` is high only in the sleep state.
- R2: While reset is held, and right after it, the domain is powered (`sw_off`=0), clamping is off, `gclk_en`=1, `dom_ready`=1, and both strobes are low.
- R3: A rising edge that samples `domain_idle` high while the domain is ready makes `gclk_en` and `dom_ready` go low after that edge. Clock stopping is always the first step of an idle period.
- R4: With threshold T on `brk_even_cycles`, `iso_en` rises after the (T+2)-th consecutive rising edge that samples `domain_idle` high, and not before. If an edge samples `domain_idle` low before that point, the controller returns to ready (`gclk_en`=1, `dom_ready`=1) after that edge and the idle count restarts from zero.
- R5: Power-down order: `iso_en` rises one cycle before the one-cycle `ret_save` pulse, and `sw_off` rises in the cycle after that pulse. `gclk_en` stays low throughout.
- R6: While `sw_off` is high, `iso_en`=1, `gclk_en`=0 and `dom_ready`=0. `domain_idle` has no effect in this state; only a wake request leaves it.
- R7: Wake order: `sw_off` falls after the edge that samples `wake_req` in sleep. With W on `wake_settle_cycles`, `ret_restore` pulses for one cycle W+1 cycles after that. `gclk_en` returns one cycle after the restore pulse, `iso_en` falls one cycle after that, and `dom_ready` rises one cycle after that.
- R8: A `wake_req` sampled during the clamp or save steps is held. The controller still reaches sleep (`sw_off` high for exactly one cycle) and then begins the wake sequence by itself.
- R9: A `wake_req` sampled while the clock is stopped but before power-down returns to ready with no clamping. While `wake_req` stays high, an idle domain is not clock-stopped.
- R10: `ret_save` and `ret_restore` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| domain_idle | input | 1 | Domain reports it has no work |
| wake_req | input | 1 | Request to bring the domain back |
| brk_even_cycles | input | IDLE_W | Break-even idle threshold T |
| wake_settle_cycles | input | WAKE_W | Supply settling count W |
| sw_off | output | 1 | Footer switch control, high = supply cut |
| sw_off_n | output | 1 | Header switch control, complement of sw_off |
| iso_en | output | 1 | Clamp the domain outputs to a fixed value |
| ret_save | output | 1 | One-cycle retention save strobe |
| ret_restore | output | 1 | One-cycle retention restore strobe |
| gclk_en | output | 1 | Clock-gate enable for the domain |
| dom_ready | output | 1 | Domain powered, clocked and unclamped |

## Verification
The bench targets the exact edge on which clamping starts for a threshold of zero and for a larger threshold. An off-by-one idle counter would cut power a cycle early or late, which shows up as a shifted `iso_en`. It also breaks an idle run one cycle before the threshold and then re-enters idle. A counter that is not cleared would then power down too early on the second run. A wake request is injected during the clamp step: a controller that drops it would stay asleep, and one that aborts the sequence would never assert `sw_off`. The wake path is timed cycle by cycle to catch a restore issued before settling is done, or a clamp released before the clock returns.

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
  parameter int IDLE_W = 16,
  parameter int WAKE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              domain_idle,
  input  logic              wake_req,
  input  logic [IDLE_W-1:0] brk_even_cycles,
  input  logic [WAKE_W-1:0] wake_settle_cycles,
  output logic              sw_off,
  output logic              sw_off_n,
  output logic              iso_en,
  output logic              ret_save,
  output logic              ret_restore,
  output logic              gclk_en,
  output logic              dom_ready
);

  typedef enum logic [3:0] {
    S_ON, S_GATED, S_CLAMP, S_SAVE, S_SLEEP,
    S_SETTLE, S_RESTORE, S_CLKON, S_UNCLAMP
  } st_t;

  st_t               st, st_nx;
  logic [IDLE_W-1:0] idle_cnt;
  logic [WAKE_W-1:0] wake_cnt;
  logic              wake_pend;

  always_comb begin
    st_nx = st;
    unique case (st)
      S_ON:      if (domain_idle && !wake_req) st_nx = S_GATED;
      S_GATED:   if (!domain_idle || wake_req) st_nx = S_ON;
                 else if (idle_cnt >= brk_even_cycles) st_nx = S_CLAMP;
      S_CLAMP:   st_nx = S_SAVE;
      S_SAVE:    st_nx = S_SLEEP;
      S_SLEEP:   if (wake_req || wake_pend) st_nx = S_SETTLE;
      S_SETTLE:  if (wake_cnt >= wake_settle_cycles) st_nx = S_RESTORE;
      S_RESTORE: st_nx = S_CLKON;
      S_CLKON:   st_nx = S_UNCLAMP;
      S_UNCLAMP: st_nx = S_ON;
      default:   st_nx = S_ON;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_ON;
      idle_cnt  <= '0;
      wake_cnt  <= '0;
      wake_pend <= 1'b0;
    end else begin
      st <= st_nx;
      if (st == S_GATED && st_nx == S_GATED) idle_cnt <= idle_cnt + 1'b1;
      else                                   idle_cnt <= '0;
      if (st == S_SETTLE && st_nx == S_SETTLE) wake_cnt <= wake_cnt + 1'b1;
      else                                     wake_cnt <= '0;
      if (st == S_SLEEP)                               wake_pend <= 1'b0;
      else if ((st == S_CLAMP || st == S_SAVE) && wake_req) wake_pend <= 1'b1;
    end
  end

  assign sw_off      = (st == S_SLEEP);
  assign sw_off_n    = (st != S_SLEEP);
  assign iso_en      = st inside {S_CLAMP, S_SAVE, S_SLEEP, S_SETTLE, S_RESTORE, S_CLKON};
  assign ret_save    = (st == S_SAVE);
  assign ret_restore = (st == S_RESTORE);
  assign gclk_en     = st inside {S_ON, S_CLKON, S_UNCLAMP};
  assign dom_ready   = (st == S_ON);

  // R1
  switch_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_off_n == !sw_off);
  // R5
  save_before_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sw_off) |-> $past(ret_save));
  // R5
  clamp_before_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_save |-> iso_en && $past(iso_en) && !gclk_en);
  // R3
  clock_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(iso_en) |-> $past(!gclk_en));
  // R6
  asleep_clamped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_off |-> iso_en && !gclk_en && !dom_ready);
  // R7
  restore_powered_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_restore |-> !sw_off && iso_en && !gclk_en);
  // R7
  unclamp_clocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(iso_en) |-> gclk_en && $past(gclk_en));
  // R10
  save_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_save |=> !ret_save);
  // R10
  restore_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_restore |=> !ret_restore);
  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ret_save && ret_restore));

endmodule

// File: tb/pwr_seq_ctrl_bench.sv
`timescale 1ns/1ps
module pwr_seq_ctrl_bench;
  logic clk = 1'b0, rst_n = 1'b0, domain_idle = 1'b0, wake_req = 1'b0;
  logic [15:0] brk_even_cycles = '0, wake_settle_cycles = '0;
  logic sw_off, sw_off_n, iso_en, ret_save, ret_restore, gclk_en, dom_ready;
  int n_checks = 0, n_err = 0;
  int r1_bad = 0, r10_bad = 0;
  logic prev_save = 1'b0, prev_rest = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwr_seq_ctrl u_pwr_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .domain_idle(domain_idle), .wake_req(wake_req),
    .brk_even_cycles(brk_even_cycles), .wake_settle_cycles(wake_settle_cycles),
    .sw_off(sw_off), .sw_off_n(sw_off_n), .iso_en(iso_en), .ret_save(ret_save),
    .ret_restore(ret_restore), .gclk_en(gclk_en), .dom_ready(dom_ready));

  always @(negedge clk) begin
    if (sw_off_n !== ~sw_off) r1_bad++;
    if ((ret_save && prev_save) || (ret_restore && prev_rest) || (ret_save && ret_restore)) r10_bad++;
    prev_save = ret_save;
    prev_rest = ret_restore;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    adv(2);
    chk("R2", "sw_off in reset", sw_off, 0);
    rst_n = 1'b1;
    adv(1);
    chk("R2", "clk_en after reset", gclk_en, 1);
    chk("R2", "ready after reset", dom_ready, 1);
    chk("R2", "iso after reset", iso_en, 0);
    chk("R2", "strobes after reset", ret_save | ret_restore, 0);
  endtask

  task automatic t_power_cycle(input int thr, input int w);
    brk_even_cycles = 16'(thr);
    wake_settle_cycles = 16'(w);
    adv(1);
    domain_idle = 1'b1;
    adv(1);
    chk("R3", "clock stopped", gclk_en, 0);
    chk("R3", "ready dropped", dom_ready, 0);
    adv(thr);
    chk("R4", "no clamp before threshold", iso_en, 0);
    adv(1);
    chk("R4", "clamp at threshold", iso_en, 1);
    chk("R5", "supply still on at clamp", sw_off, 0);
    adv(1);
    chk("R5", "save after clamp", ret_save, 1);
    chk("R5", "supply on during save", sw_off, 0);
    adv(1);
    chk("R5", "supply cut after save", sw_off, 1);
    chk("R1", "header switch off", sw_off_n, 0);
    chk("R6", "clamped asleep", iso_en, 1);
    domain_idle = 1'b0;
    adv(3);
    chk("R6", "idle drop ignored asleep", sw_off, 1);
    chk("R6", "clock off asleep", gclk_en, 0);
    wake_req = 1'b1;
    adv(1);
    wake_req = 1'b0;
    chk("R7", "supply back", sw_off, 0);
    chk("R7", "still clamped settling", iso_en, 1);
    adv(w);
    chk("R7", "no restore while settling", ret_restore, 0);
    adv(1);
    chk("R7", "restore after settle", ret_restore, 1);
    adv(1);
    chk("R7", "clock back", gclk_en, 1);
    chk("R7", "clamp held with clock", iso_en, 1);
    adv(1);
    chk("R7", "clamp released", iso_en, 0);
    chk("R7", "not ready yet", dom_ready, 0);
    adv(1);
    chk("R7", "ready", dom_ready, 1);
  endtask

  task automatic t_short_idle();
    brk_even_cycles = 16'd5;
    adv(1);
    domain_idle = 1'b1;
    adv(6);
    chk("R4", "short idle no clamp", iso_en, 0);
    domain_idle = 1'b0;
    adv(1);
    chk("R4", "back to ready", dom_ready, 1);
    chk("R4", "clock back", gclk_en, 1);
    domain_idle = 1'b1;
    adv(6);
    chk("R4", "count restarted", iso_en, 0);
    adv(1);
    chk("R4", "clamp after full run", iso_en, 1);
    adv(2);
    domain_idle = 1'b0;
    wake_req = 1'b1;
    adv(1);
    wake_req = 1'b0;
    adv(10);
    chk("R7", "recovered", dom_ready, 1);
  endtask

  task automatic t_wake_gated();
    brk_even_cycles = 16'd10;
    adv(1);
    domain_idle = 1'b1;
    adv(3);
    wake_req = 1'b1;
    adv(1);
    chk("R9", "wake in gated ready", dom_ready, 1);
    chk("R9", "wake in gated no clamp", iso_en, 0);
    adv(3);
    chk("R9", "held wake keeps clock", gclk_en, 1);
    wake_req = 1'b0;
    domain_idle = 1'b0;
    adv(2);
  endtask

  task automatic t_wake_pending();
    brk_even_cycles = 16'd2;
    wake_settle_cycles = 16'd3;
    adv(1);
    domain_idle = 1'b1;
    adv(4);
    chk("R8", "clamp reached", iso_en, 1);
    wake_req = 1'b1;
    adv(1);
    wake_req = 1'b0;
    domain_idle = 1'b0;
    chk("R8", "save still runs", ret_save, 1);
    adv(1);
    chk("R8", "sleep reached", sw_off, 1);
    adv(1);
    chk("R8", "pending wake served", sw_off, 0);
    adv(4);
    chk("R8", "restore after pending wake", ret_restore, 1);
    adv(3);
    chk("R8", "ready after pending wake", dom_ready, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_power_cycle(0, 0);
    t_power_cycle(4, 6);
    t_short_idle();
    t_wake_gated();
    t_wake_pending();
    chk("R1", "complement violations", r1_bad, 0);
    chk("R10", "strobe width violations", r10_bad, 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule